// File: doc/BRIEF.md
# Reference Clock Selector with Power-of-Two Postscaler

This block picks the reference that feeds the system clock. Three references are available: an on-chip oscillator, a crystal oscillator and an external clock pin. A PLL output can also be used instead of the bare reference. The chosen clock passes through a postscaler that divides by a power of two from 1 to 256. Its output leaves the block as the double-rate clock. A final divide-by-two stage turns it into the system clock, whose high and low phases are equal. The oscillators and the PLL lie outside the block. Each one arrives as a clock level, plus a ready or lock flag where one applies.

All logic runs on one fast sampling clock `clk`. Each source level passes through a two-flop synchronizer. Every edge of that level, rising or falling, then becomes one tick. The postscaler counts ticks of the active source, so `clk2x_o` keeps one level for N source edges. Source changes are handled by a three-state controller. In `ST_RUN` the selection is steady. The transition RUN→DRAIN fires when the requested source or PLL choice differs from the active one and the request is ready. In `ST_DRAIN` the old clock keeps running until the postscaler's terminal count drives `clk2x_o` low. DRAIN→SYNC fires on that falling terminal. In `ST_SYNC` the postscaler is frozen while two ticks of the new clock are counted. SYNC→RUN fires on the second tick and makes the new selection active. A reference-loss event in any state forces a return to `ST_RUN` on the on-chip oscillator with the PLL deselected.

A loss monitor runs while the PLL is active. It counts sampling cycles between ticks of the PLL's reference. When `LOSS_WIN` cycles pass with no tick, it drops the PLL, falls back to the on-chip oscillator and sets a sticky loss flag. Power-down requests for the on-chip oscillator, the crystal oscillator and the PLL are honoured only when that clock is not in use.

Top module: `clk_source_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the active source is the on-chip oscillator (code 0). The PLL is deselected and `clk2x_o`, `sys_clk_o`, `loss_flag_o` and `switch_pending_o` are 0. `int_mode_o` is 0 (run).
- R2: `clk2x_o` toggles once for every N edges (rising or falling) of the active clock. That clock is the PLL input when `pll_active_o` is 1 and otherwise the reference whose code is on `active_src_o` (0 on-chip, 1 crystal, 2 external). N is 2 to the power `post_code_i` for codes 0 to 8; codes 9 to 15 give N = 256.
- R3: `sys_clk_o` toggles exactly in the cycles where `clk2x_o` rises and in no other cycle, so it has exactly half the frequency of `clk2x_o` and a 50% duty cycle.
- R4: A new `post_code_i` is taken up only at the terminal count of the postscaler. The period in progress completes with the old N, and the following period uses the code present at that terminal count.
- R5: A request that differs from the active selection is held while it is not ready. Meanwhile `switch_pending_o` is 1 and the active selection does not change. The requested source counts as ready under these conditions: for code 0, `int_mode_o` is run; for code 1, `xtal_ready_i` is 1 and `xtal_pd_o` is 0; for code 2, `ext_ready_i` is 1. Code 3 is never ready. A request with `pll_sel_i` = 1 also needs `pll_lock_i` = 1 and `pll_pd_o` = 0.
- R6: A ready switch completes in three steps. First the old clock runs until `clk2x_o` falls at a terminal count. Then both outputs are frozen with `clk2x_o` low while two edges of the new clock are seen. Only then do `active_src_o` and `pll_active_o` take the requested values. `clk2x_o` is low in the cycle the selection changes.
- R7: While the PLL is active, suppose `LOSS_WIN` (default 16) sampling cycles pass with no synchronized edge of the reference. Then `pll_active_o` drops, `active_src_o` becomes 0 and `loss_flag_o` is set.
- R8: A power-down request for a clock that is active or is the target of a switch in progress is refused. Otherwise `xtal_pd_o` and `pll_pd_o` follow their requests, one cycle later.
- R9: `int_mode_o` is 0 for run, 1 for standby and 2 for power-down. Power-down takes priority over standby, and both are refused while the on-chip oscillator is in use.
- R10: `loss_flag_o` stays set until `loss_clr_i` is pulsed (or reset). While it is set, no source switch is started and `switch_pending_o` shows any differing request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_osc_i | input | 1 | On-chip oscillator level |
| xtal_osc_i | input | 1 | Crystal oscillator level |
| ext_clk_i | input | 1 | External clock pin level |
| pll_clk_i | input | 1 | PLL output level |
| xtal_ready_i | input | 1 | Crystal oscillator enabled and stable |
| ext_ready_i | input | 1 | External clock enabled and stable |
| pll_lock_i | input | 1 | PLL locked |
| src_sel_i | input | 2 | Requested reference: 0 on-chip, 1 crystal, 2 external |
| pll_sel_i | input | 1 | Request the PLL output instead of the bare reference |
| post_code_i | input | CODE_W | Postscaler code, N = 2^min(code,8) |
| int_pd_req_i | input | 1 | Power-down request, on-chip oscillator |
| int_stby_req_i | input | 1 | Standby request, on-chip oscillator |
| xtal_pd_req_i | input | 1 | Power-down request, crystal oscillator |
| pll_pd_req_i | input | 1 | Power-down request, PLL |
| loss_clr_i | input | 1 | Write-one-to-clear for the loss flag |
| clk2x_o | output | 1 | Postscaler output (double-rate clock) |
| sys_clk_o | output | 1 | System clock, half of clk2x_o, 50% duty |
| active_src_o | output | 2 | Reference currently in use |
| pll_active_o | output | 1 | PLL output currently in use |
| switch_pending_o | output | 1 | Request differs from the active selection or a switch is under way |
| loss_flag_o | output | 1 | Sticky reference-loss flag |
| int_mode_o | output | 2 | On-chip oscillator mode: 0 run, 1 standby, 2 off |
| xtal_pd_o | output | 1 | Crystal oscillator power-down |
| pll_pd_o | output | 1 | PLL power-down |

## Verification
The hardest state to reach is a reference loss while the PLL is selected. Getting there takes a full switch first: a held request, then the ready flag, then the PLL lock. After that, one reference must go silent while the PLL input keeps running. The bench builds up to this in that order and then stops only the crystal level. It brackets the detection time from the known edge spacing, so the check is neither early nor late. Period checks count the edges the bench itself produced between output toggles. Random postscaler codes are changed at arbitrary cycles, so many changes land in the middle of a period.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
    typedef enum logic [1:0] {
        SRC_INT  = 2'd0,
        SRC_XTAL = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_RSVD = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_SYNC  = 2'd2
    } sw_state_e;

    typedef enum logic [1:0] {
        OSC_RUN  = 2'd0,
        OSC_STBY = 2'd1,
        OSC_OFF  = 2'd2
    } osc_mode_e;

    localparam int NUM_CLK = 4;
    localparam int PLL_IDX = 3;
endpackage

// File: rtl/clksel_edge_det.sv
module clksel_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic tick_o
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= lvl_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // any settled level change is one source edge
    assign tick_o = s2_q ^ s3_q;
endmodule

// File: rtl/clksel_postscale.sv
module clksel_postscale #(
    parameter int CODE_W  = 4,
    parameter int MAX_LOG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              hold_i,
    input  logic              restart_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              clk2x_o,
    output logic              sys_o,
    output logic              fall_o
);
    localparam int CNT_W = (MAX_LOG > 0) ? MAX_LOG : 1;
    localparam int SH_W  = $clog2(MAX_LOG + 1);

    logic [SH_W-1:0]  sh_q, sh_new;
    logic [CNT_W-1:0] cnt_q, lim;
    logic             clk2x_q, sys_q, term;

    assign sh_new = (code_i > CODE_W'(MAX_LOG)) ? SH_W'(MAX_LOG) : SH_W'(code_i);
    assign lim    = CNT_W'((1 << sh_q) - 1);
    assign term   = tick_i && !hold_i && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            clk2x_q <= 1'b0;
            sys_q   <= 1'b0;
        end else begin
            if (restart_i || term) begin
                cnt_q <= '0;
            end else if (tick_i && !hold_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (term) begin
                sh_q    <= sh_new;
                clk2x_q <= ~clk2x_q;
                if (!clk2x_q) begin
                    sys_q <= ~sys_q;
                end
            end
        end
    end

    assign clk2x_o = clk2x_q;
    assign sys_o   = sys_q;
    assign fall_o  = term && clk2x_q;

    // R3
    sys_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sys_q) |-> $rose(clk2x_q));

    // R4
    code_at_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sh_q) |-> !$stable(clk2x_q));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);
endmodule

// File: rtl/clksel_loss_mon.sv
module clksel_loss_mon #(
    parameter int WIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic ref_tick_i,
    input  logic clr_i,
    output logic loss_o,
    output logic flag_o
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] gap_q;
    logic          flag_q;

    assign loss_o = en_i && !ref_tick_i && (gap_q == CW'(WIN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (!en_i || ref_tick_i || loss_o) begin
                gap_q <= '0;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
            if (loss_o) begin
                flag_q <= 1'b1;
            end else if (clr_i) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign flag_o = flag_q;

    // R7
    loss_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loss_o |=> flag_q);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(clr_i));
endmodule

// File: rtl/clksel_switch_fsm.sv
module clksel_switch_fsm
    import clksel_pkg::*;
#(
    parameter int SYNC_EDGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         req_src_i,
    input  logic               req_pll_i,
    input  logic               req_ready_i,
    input  logic [NUM_CLK-1:0] ticks_i,
    input  logic               fall_i,
    input  logic               loss_i,
    output logic [1:0]         active_src_o,
    output logic               pll_active_o,
    output logic [1:0]         tgt_src_o,
    output logic               tgt_pll_o,
    output logic               hold_o,
    output logic               restart_o,
    output logic               busy_o,
    output logic               pending_o
);
    localparam int SC_W = $clog2(SYNC_EDGES + 1);

    sw_state_e       state_q, state_d;
    src_e            active_q, tgt_q;
    logic            pll_q, tgt_pll_q;
    logic [SC_W-1:0] sync_q;
    logic            differs, new_tick, sync_done;

    assign differs   = (src_e'(req_src_i) != active_q) || (req_pll_i != pll_q);
    assign new_tick  = tgt_pll_q ? ticks_i[PLL_IDX] : ticks_i[tgt_q];
    assign sync_done = new_tick && (sync_q == SC_W'(SYNC_EDGES - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (differs && req_ready_i) state_d = ST_DRAIN;
            ST_DRAIN: if (fall_i)                 state_d = ST_SYNC;
            ST_SYNC:  if (sync_done)              state_d = ST_RUN;
            default:                              state_d = ST_RUN;
        endcase
        if (loss_i) begin
            state_d = ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q  <= SRC_INT;
            pll_q     <= 1'b0;
            tgt_q     <= SRC_INT;
            tgt_pll_q <= 1'b0;
            sync_q    <= '0;
        end else if (loss_i) begin
            active_q <= SRC_INT;
            pll_q    <= 1'b0;
            sync_q   <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    sync_q <= '0;
                    if (state_d == ST_DRAIN) begin
                        tgt_q     <= src_e'(req_src_i);
                        tgt_pll_q <= req_pll_i;
                    end
                end
                ST_DRAIN: sync_q <= '0;
                ST_SYNC: begin
                    if (sync_done) begin
                        active_q <= tgt_q;
                        pll_q    <= tgt_pll_q;
                        sync_q   <= '0;
                    end else if (new_tick) begin
                        sync_q <= sync_q + 1'b1;
                    end
                end
                default: sync_q <= '0;
            endcase
        end
    end

    assign active_src_o = active_q;
    assign pll_active_o = pll_q;
    assign tgt_src_o    = tgt_q;
    assign tgt_pll_o    = tgt_pll_q;
    assign hold_o       = (state_q == ST_SYNC);
    assign restart_o    = loss_i;
    assign busy_o       = (state_q != ST_RUN);
    assign pending_o    = busy_o || differs;

    // R6
    sel_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(active_q) || !$stable(pll_q)) |-> ($past(state_q) == ST_SYNC || $past(loss_i)));
endmodule

// File: rtl/clk_source_ctrl.sv
module clk_source_ctrl
    import clksel_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int MAX_LOG    = 8,
    parameter int LOSS_WIN   = 16,
    parameter int SYNC_EDGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_osc_i,
    input  logic              xtal_osc_i,
    input  logic              ext_clk_i,
    input  logic              pll_clk_i,
    input  logic              xtal_ready_i,
    input  logic              ext_ready_i,
    input  logic              pll_lock_i,
    input  logic [1:0]        src_sel_i,
    input  logic              pll_sel_i,
    input  logic [CODE_W-1:0] post_code_i,
    input  logic              int_pd_req_i,
    input  logic              int_stby_req_i,
    input  logic              xtal_pd_req_i,
    input  logic              pll_pd_req_i,
    input  logic              loss_clr_i,
    output logic              clk2x_o,
    output logic              sys_clk_o,
    output logic [1:0]        active_src_o,
    output logic              pll_active_o,
    output logic              switch_pending_o,
    output logic              loss_flag_o,
    output logic [1:0]        int_mode_o,
    output logic              xtal_pd_o,
    output logic              pll_pd_o
);
    logic [NUM_CLK-1:0] lvl, ticks;
    logic [1:0]         active_src, tgt_src;
    logic               pll_active, tgt_pll, hold, restart, busy, pending;
    logic               fall, loss, loss_flag, sel_tick, ref_tick;
    logic               src_ok, pll_ok, req_ready;
    logic               int_use, xtal_use, pll_use;
    osc_mode_e          int_mode_q;
    logic               xtal_pd_q, pll_pd_q;

    assign lvl = {pll_clk_i, ext_clk_i, xtal_osc_i, int_osc_i};

    for (genvar g = 0; g < NUM_CLK; g++) begin : g_sync
        clksel_edge_det u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (lvl[g]),
            .tick_o (ticks[g])
        );
    end

    assign ref_tick = ticks[active_src];
    assign sel_tick = pll_active ? ticks[PLL_IDX] : ref_tick;

    always_comb begin
        case (src_e'(src_sel_i))
            SRC_INT:  src_ok = (int_mode_q == OSC_RUN);
            SRC_XTAL: src_ok = xtal_ready_i && !xtal_pd_q;
            SRC_EXT:  src_ok = ext_ready_i;
            default:  src_ok = 1'b0;
        endcase
    end
    assign pll_ok    = !pll_sel_i || (pll_lock_i && !pll_pd_q);
    assign req_ready = src_ok && pll_ok && !loss_flag;

    clksel_switch_fsm #(.SYNC_EDGES(SYNC_EDGES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_src_i    (src_sel_i),
        .req_pll_i    (pll_sel_i),
        .req_ready_i  (req_ready),
        .ticks_i      (ticks),
        .fall_i       (fall),
        .loss_i       (loss),
        .active_src_o (active_src),
        .pll_active_o (pll_active),
        .tgt_src_o    (tgt_src),
        .tgt_pll_o    (tgt_pll),
        .hold_o       (hold),
        .restart_o    (restart),
        .busy_o       (busy),
        .pending_o    (pending)
    );

    clksel_postscale #(.CODE_W(CODE_W), .MAX_LOG(MAX_LOG)) u_post (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (sel_tick),
        .hold_i    (hold),
        .restart_i (restart),
        .code_i    (post_code_i),
        .clk2x_o   (clk2x_o),
        .sys_o     (sys_clk_o),
        .fall_o    (fall)
    );

    clksel_loss_mon #(.WIN(LOSS_WIN)) u_loss (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (pll_active),
        .ref_tick_i (ref_tick),
        .clr_i      (loss_clr_i),
        .loss_o     (loss),
        .flag_o     (loss_flag)
    );

    assign int_use  = (src_e'(active_src) == SRC_INT)  || (busy && src_e'(tgt_src) == SRC_INT);
    assign xtal_use = (src_e'(active_src) == SRC_XTAL) || (busy && src_e'(tgt_src) == SRC_XTAL);
    assign pll_use  = pll_active || (busy && tgt_pll);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_mode_q <= OSC_RUN;
            xtal_pd_q  <= 1'b0;
            pll_pd_q   <= 1'b0;
        end else begin
            if (int_use)             int_mode_q <= OSC_RUN;
            else if (int_pd_req_i)   int_mode_q <= OSC_OFF;
            else if (int_stby_req_i) int_mode_q <= OSC_STBY;
            else                     int_mode_q <= OSC_RUN;
            xtal_pd_q <= xtal_pd_req_i && !xtal_use;
            pll_pd_q  <= pll_pd_req_i && !pll_use;
        end
    end

    assign active_src_o     = active_src;
    assign pll_active_o     = pll_active;
    assign switch_pending_o = pending;
    assign loss_flag_o      = loss_flag;
    assign int_mode_o       = int_mode_q;
    assign xtal_pd_o        = xtal_pd_q;
    assign pll_pd_o         = pll_pd_q;

    // R8
    pll_off_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_pd_q |-> !pll_active);

    // R8
    xtal_off_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xtal_pd_q |-> (src_e'(active_src) != SRC_XTAL));
endmodule

// File: tb/clk_source_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_source_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] lvl = 4'b0;
    logic [3:0] run_en = 4'b1111;
    logic       xtal_ready = 0, ext_ready = 0, pll_lock = 0, pll_sel = 0;
    logic [1:0] src_sel = 2'd0;
    logic [3:0] post_code = 4'd0;
    logic       int_pd_req = 0, int_stby_req = 0, xtal_pd_req = 0, pll_pd_req = 0, loss_clr = 0;
    logic       clk2x, sys_clk, pll_active, pending, loss_flag, xtal_pd, pll_pd;
    logic [1:0] active_src, int_mode;

    int compared = 0, mismatched = 0;
    int edge_cnt [4];
    int cyc = 0, tog_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    clk_source_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .int_osc_i(lvl[0]), .xtal_osc_i(lvl[1]), .ext_clk_i(lvl[2]), .pll_clk_i(lvl[3]),
        .xtal_ready_i(xtal_ready), .ext_ready_i(ext_ready), .pll_lock_i(pll_lock),
        .src_sel_i(src_sel), .pll_sel_i(pll_sel), .post_code_i(post_code),
        .int_pd_req_i(int_pd_req), .int_stby_req_i(int_stby_req),
        .xtal_pd_req_i(xtal_pd_req), .pll_pd_req_i(pll_pd_req), .loss_clr_i(loss_clr),
        .clk2x_o(clk2x), .sys_clk_o(sys_clk), .active_src_o(active_src),
        .pll_active_o(pll_active), .switch_pending_o(pending), .loss_flag_o(loss_flag),
        .int_mode_o(int_mode), .xtal_pd_o(xtal_pd), .pll_pd_o(pll_pd)
    );

    function automatic int div_of(input logic [3:0] code);
        return 1 << ((code > 4'd8) ? 8 : int'(code));
    endfunction

    function automatic int half_of(input int i);
        case (i)
            0: return 6;
            1: return 8;
            2: return 10;
            default: return 6;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor first, then source drivers, all at the falling edge
    bit armed = 0;
    logic prev_x = 0, prev_s = 0;
    int last_id = 0, prev_id = 0, last_cnt = 0, exp_n = 1;
    always @(negedge clk) begin
        int cur_id;
        if (!rst_n) begin
            armed = 0; prev_x = 0; prev_s = 0; prev_id = 0; last_id = 0; exp_n = 1;
        end else begin
            cur_id = pll_active ? 3 : int'(active_src);
            if (cur_id != prev_id && !loss_flag)
                chk(clk2x == 1'b0, "R6 clk2x low when selection changes", clk2x, 0);
            prev_id = cur_id;
            if (clk2x != prev_x) begin
                if (armed && cur_id == last_id)
                    chk(edge_cnt[cur_id] - last_cnt == exp_n, "R2 R4 edges per clk2x phase",
                        edge_cnt[cur_id] - last_cnt, exp_n);
                chk(clk2x ? (sys_clk != prev_s) : (sys_clk == prev_s),
                    "R3 sys toggles on clk2x rise only", sys_clk, clk2x ? !prev_s : prev_s);
                last_cnt = edge_cnt[cur_id];
                last_id  = cur_id;
                armed    = 1;
                exp_n    = div_of(post_code);
                tog_cnt++;
            end else if (sys_clk != prev_s) begin
                chk(1'b0, "R3 sys toggled without clk2x rise", sys_clk, prev_s);
            end
            prev_x = clk2x;
            prev_s = sys_clk;
        end
        cyc++;
        for (int i = 0; i < 4; i++) begin
            if (run_en[i] && (cyc % half_of(i) == 0)) begin
                lvl[i] = ~lvl[i];
                edge_cnt[i]++;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_toggles(input int n);
        int start = tog_cnt;
        int guard = 0;
        while (tog_cnt < start + n && guard < 20000) begin
            step(1);
            guard++;
        end
        chk(tog_cnt >= start + n, "R2 clk2x keeps toggling", tog_cnt - start, n);
    endtask

    task automatic wait_sel(input int id, input string tag);
        int guard = 0;
        while ((pll_active ? 3 : int'(active_src)) != id && guard < 5000) begin
            step(1);
            guard++;
        end
        chk((pll_active ? 3 : int'(active_src)) == id, tag, pll_active ? 3 : active_src, id);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stim
        logic [3:0] rc;
        void'($urandom(32'd5150));
        step(5);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(active_src == 2'd0, "R1 active source", active_src, 0);
        chk(!pll_active, "R1 pll deselected", pll_active, 0);
        chk(!clk2x && !sys_clk, "R1 outputs low", {clk2x, sys_clk}, 0);
        chk(!loss_flag && !pending, "R1 flag and pending", {loss_flag, pending}, 0);
        chk(int_mode == 2'd0, "R1 on-chip oscillator runs", int_mode, 0);

        // R2/R3/R4 directed codes including the clamp above 8
        foreach (rc_list[k]) begin
            post_code = rc_list[k];
            wait_toggles(3);
        end
        for (int k = 0; k < 6; k++) begin
            rc = 4'($urandom % 16);
            if (rc > 4'd6 && k > 1) rc = 4'($urandom % 5);
            post_code = rc;
            step(int'($urandom % 40));
            wait_toggles(3);
        end
        post_code = 4'd2;
        wait_toggles(2);

        // R8/R9 on-chip oscillator in use: power-down refused
        int_pd_req = 1;
        step(3);
        chk(int_mode == 2'd0, "R8 R9 in-use power-down refused", int_mode, 0);
        int_pd_req = 0;

        // R5 hold while crystal not ready
        src_sel = 2'd1;
        step(300);
        chk(active_src == 2'd0, "R5 held on current source", active_src, 0);
        chk(pending, "R5 pending while not ready", pending, 1);
        xtal_ready = 1;
        wait_sel(1, "R6 switched to crystal");
        wait_toggles(3);

        // R8 crystal in use, on-chip oscillator idle
        xtal_pd_req = 1;
        int_pd_req  = 1;
        step(3);
        chk(!xtal_pd, "R8 crystal power-down refused", xtal_pd, 0);
        chk(int_mode == 2'd2, "R8 R9 idle oscillator powered down", int_mode, 2);
        int_pd_req = 0; int_stby_req = 1;
        step(3);
        chk(int_mode == 2'd1, "R9 standby", int_mode, 1);
        int_pd_req = 1;
        step(3);
        chk(int_mode == 2'd2, "R9 power-down over standby", int_mode, 2);
        int_pd_req = 0; int_stby_req = 0; xtal_pd_req = 0;
        pll_pd_req = 1;
        step(3);
        chk(pll_pd, "R8 idle pll powered down", pll_pd, 1);
        pll_pd_req = 0;
        step(2);

        // R5 pll request held until lock
        pll_sel = 1;
        step(200);
        chk(!pll_active && pending, "R5 pll held without lock", {pll_active, pending}, 1);
        pll_lock = 1;
        wait_sel(3, "R6 switched to pll");
        pll_pd_req = 1;
        step(3);
        chk(!pll_pd, "R8 active pll power-down refused", pll_pd, 0);
        pll_pd_req = 0;
        wait_toggles(3);

        // R7 reference loss
        run_en[1] = 0;
        step(10);
        chk(!loss_flag, "R7 no loss before window", loss_flag, 0);
        step(12);
        chk(loss_flag, "R7 loss flagged", loss_flag, 1);
        chk(!pll_active && active_src == 2'd0, "R7 fallback to on-chip", {pll_active, active_src}, 0);

        // R10 sticky and blocking
        step(200);
        chk(loss_flag, "R10 flag sticky", loss_flag, 1);
        chk(active_src == 2'd0 && !pll_active, "R10 no switch while flagged", active_src, 0);
        chk(pending, "R10 pending while flagged", pending, 1);
        src_sel = 2'd0; pll_sel = 0;
        step(2);
        loss_clr = 1;
        step(1);
        loss_clr = 0;
        step(2);
        chk(!loss_flag, "R10 flag cleared", loss_flag, 0);
        wait_toggles(2);

        // external clock with random code
        run_en[1] = 1;
        ext_ready = 1;
        post_code = 4'($urandom % 4);
        src_sel = 2'd2;
        wait_sel(2, "R6 switched to external");
        wait_toggles(3);
        src_sel = 2'd0;
        wait_sel(0, "R6 back to on-chip");
        wait_toggles(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    logic [3:0] rc_list [4] = '{4'd0, 4'd3, 4'd8, 4'd13};
endmodule